// File: doc/BRIEF.md
# Four-Phase Interpolating Thermometer Envelope Driver

This block sits between a digital envelope source and an array of equal-weight unit cells whose currents add at a shared output. Each sample period it takes a 6-bit envelope code and drives four banks of 64 cell enables. Each bank holds a thermometer pattern, so a bank whose code is `v` has exactly `v` cells on. Inside a bank the cells form an 8x8 array. The upper code bits choose the rows that are fully on, and the lower bits choose how far the next row is filled.

The block runs on one clock at four times the sample rate. The banks take up a new code one after another, one fast cycle apart. Between two samples the summed number of active cells therefore climbs or falls in four equal steps rather than in one jump. This staircase approximates linear interpolation and reduces the sampling images of the amplitude path.

Three controls adjust the behaviour:
- A bypass input turns every cell on, so the array behaves as a plain linear amplifier.
- A single-phase input makes all banks update together.
- A delay setting, taken while reset is asserted, holds the envelope back by a whole number of sample periods so that it lines up with a separately generated phase path.

Top module: `env_interp_driver`

## Requirements
- R1: While reset is asserted, every delay stage, the held code, the phase counter and every bank are cleared. After reset, with bypass low, all 256 enables and the total are zero.
- R2: Cell index `i` within a bank is `row*8+col`, and it drives output bit `bank*64+i`. A bank holding code `v` enables exactly the cells whose row is below `v[5:3]`, plus the cells whose row equals `v[5:3]` and whose column is below `v[2:0]`. This is the same as index `i < v`.
- R3: With single-phase low, a strobe sampled at clock edge E0 loads the delayed code into the held register. Bank 0 takes it at E1, bank 1 at E2, bank 2 at E3 and bank 3 at E4. After k of these edges the total is `old*(4-k)+new*k`, and no two banks change on the same edge.
- R4: When two successive codes differ by one, each bank update toggles exactly one cell enable.
- R5: `active_total` always equals the number of asserted bits of `cell_en`, in the range 0 to 256.
- R6: Bypass high forces all 256 enables to one and the total to 256, whatever the code. The banks keep following new samples during bypass, so when bypass is released the outputs show the latest code.
- R7: With single-phase high, all four banks load the held code together at E1. The total moves from `4*old` to `4*new` in one step.
- R8: A delay setting N (0 to 15), sampled only while reset is asserted, makes the code sampled at strobe j reach the banks at strobe j+N. Codes from before the first N strobes appear as zero. Changing the setting after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| code_in | input | 6 | Envelope code, valid with the strobe |
| sample_stb | input | 1 | One-cycle pulse per sample period |
| bypass | input | 1 | Force every cell enable high |
| single_phase | input | 1 | Update all banks on the same edge |
| delay_cfg | input | 4 | Envelope delay in sample periods, taken during reset |
| cell_en | output | 256 | Unit-cell enables, bank b at bits b*64+63 down to b*64 |
| active_total | output | 9 | Number of enabled cells across all banks |

## Verification
The assertions check four things on every cycle:
- each bank pattern stays a contiguous thermometer prefix;
- the total matches the popcount of the enables;
- bypass forces all cells on;
- in staggered mode no more than one bank changes per edge.

Only the directed scenarios can show the parts that depend on values and timing together: the exact staircase levels between two chosen codes, the single-cell toggle for a one-LSB step, the one-edge jump in single-phase mode, and the sample alignment produced by the reset-time delay setting, including that a later change of that setting is ignored.

// File: rtl/env_drv_pkg.sv
// Package env_drv_pkg
// Shared default geometry for the envelope driver and the bank load modes.
// Assumes the code width splits into a row field and a column field.
package env_drv_pkg;
    localparam int DEF_CODE_W      = 6;
    localparam int DEF_COL_W       = 3;
    localparam int DEF_BANKS       = 4;
    localparam int DEF_DELAY_DEPTH = 15;
    localparam int DEF_DELAY_SEL_W = 4;

    typedef enum logic {
        LOAD_STAGGERED = 1'b0,
        LOAD_TOGETHER  = 1'b1
    } load_mode_e;
endpackage

// File: rtl/env_delay_line.sv
// Module env_delay_line
// Holds the envelope code back by a whole number of sample periods.
// The stages shift on each sample strobe. The tap is chosen by a setting
// that is captured only while reset is asserted. A setting of zero passes
// the input straight through. Assumes DEPTH >= 1.
module env_delay_line #(
    parameter int CODE_W = 6,
    parameter int DEPTH  = 15,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [SEL_W-1:0]  sel_cfg,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] dout
);
    logic [SEL_W-1:0]  sel_q;
    logic [SEL_W-1:0]  sel_eff;
    logic [CODE_W-1:0] stage_q [DEPTH];

    // Capture the delay setting only during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= sel_cfg;
        end
    end

    // Clamp a setting beyond the built depth to the deepest tap.
    always_comb begin
        if (int'(sel_q) > DEPTH) begin
            sel_eff = SEL_W'(DEPTH);
        end else begin
            sel_eff = sel_q;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_stage
            if (gi == 0) begin : g_head
                // First stage takes the live code on each strobe.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        stage_q[gi] <= '0;
                    end else if (shift_en) begin
                        stage_q[gi] <= din;
                    end
                end
            end else begin : g_body
                // Later stages take their neighbour's value on each strobe.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        stage_q[gi] <= '0;
                    end else if (shift_en) begin
                        stage_q[gi] <= stage_q[gi-1];
                    end
                end
            end
        end
    endgenerate

    // Select the tap that matches the captured setting.
    always_comb begin
        dout = din;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel_eff == SEL_W'(i + 1)) begin
                dout = stage_q[i];
            end
        end
    end
endmodule

// File: rtl/env_phase_seq.sv
// Module env_phase_seq
// Fast-cycle phase counter that restarts on each sample strobe and chooses
// which bank loads the held code on each edge. In together mode every bank
// loads at phase zero. Assumes BANKS >= 2.
module env_phase_seq
    import env_drv_pkg::*;
#(
    parameter int BANKS = 4,
    localparam int PH_W = $clog2(BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  load_mode_e       mode,
    output logic [BANKS-1:0] load
);
    logic [PH_W-1:0] ph_q;

    // Count fast cycles within a sample period; restart on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (restart) begin
            ph_q <= '0;
        end else if (ph_q == PH_W'(BANKS - 1)) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    genvar gb;
    generate
        for (gb = 0; gb < BANKS; gb++) begin : g_load
            // A bank loads on its own phase, or on phase zero in together mode.
            assign load[gb] = (mode == LOAD_TOGETHER) ? (ph_q == '0)
                                                      : (ph_q == PH_W'(gb));
        end
    endgenerate
endmodule

// File: rtl/env_therm_bank.sv
// Module env_therm_bank
// One bank of unit-cell enables. The incoming code is decoded as a
// row/column thermometer: the upper bits give the fully-on rows and the
// lower bits fill the next row. The decoded pattern is registered on load,
// so the enables leave the bank straight from flops. Count equals the
// loaded code.
module env_therm_bank #(
    parameter int CODE_W = 6,
    parameter int COL_W  = 3,
    localparam int ROW_W = CODE_W - COL_W,
    localparam int NROW  = 1 << ROW_W,
    localparam int NCOL  = 1 << COL_W,
    localparam int CELLS = NROW * NCOL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    output logic [CELLS-1:0]  en,
    output logic [CODE_W-1:0] count
);
    logic [ROW_W-1:0]  rows;
    logic [COL_W-1:0]  cols;
    logic [NROW-1:0]   row_full;
    logic [NROW-1:0]   row_part;
    logic [NCOL-1:0]   col_on;
    logic [CELLS-1:0]  dec;
    logic [CELLS-1:0]  en_q;
    logic [CODE_W-1:0] code_q;

    assign rows = code_in[CODE_W-1 -: ROW_W];
    assign cols = code_in[COL_W-1:0];

    genvar gr, gc;
    generate
        for (gr = 0; gr < NROW; gr++) begin : g_row
            // Row thermometer: fully-on rows and the single partial row.
            assign row_full[gr] = (rows > ROW_W'(gr));
            assign row_part[gr] = (rows == ROW_W'(gr));
        end
        for (gc = 0; gc < NCOL; gc++) begin : g_col
            // Column thermometer for the partial row.
            assign col_on[gc] = (cols > COL_W'(gc));
        end
        for (gr = 0; gr < NROW; gr++) begin : g_cell_r
            for (gc = 0; gc < NCOL; gc++) begin : g_cell_c
                // A cell is on in a full row, or in the partial row below the column fill.
                assign dec[gr*NCOL + gc] = row_full[gr] | (row_part[gr] & col_on[gc]);
            end
        end
    endgenerate

    // Register the decoded pattern and the code on this bank's load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            code_q <= '0;
        end else if (load) begin
            en_q   <= dec;
            code_q <= code_in;
        end
    end

    assign en    = en_q;
    assign count = code_q;
endmodule

// File: rtl/env_interp_driver.sv
// Module env_interp_driver
// Top of the four-phase interpolating envelope driver. The code goes
// through the reset-configured delay line. On each strobe the delayed code
// is held, and the phase sequencer then hands it to the banks one fast
// cycle apart. Bypass forces every enable high at the output. The total is
// the sum of the bank counts, or the full cell count in bypass.
// Assumes the clock runs at BANKS times the sample rate.
module env_interp_driver
    import env_drv_pkg::*;
#(
    parameter int CODE_W      = DEF_CODE_W,
    parameter int COL_W       = DEF_COL_W,
    parameter int BANKS       = DEF_BANKS,
    parameter int DELAY_DEPTH = DEF_DELAY_DEPTH,
    parameter int DELAY_SEL_W = DEF_DELAY_SEL_W,
    localparam int CELLS      = 1 << CODE_W,
    localparam int ALL_CELLS  = BANKS * CELLS,
    localparam int TOTAL_W    = $clog2(ALL_CELLS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CODE_W-1:0]      code_in,
    input  logic                   sample_stb,
    input  logic                   bypass,
    input  logic                   single_phase,
    input  logic [DELAY_SEL_W-1:0] delay_cfg,
    output logic [ALL_CELLS-1:0]   cell_en,
    output logic [TOTAL_W-1:0]     active_total
);
    logic [CODE_W-1:0]    delayed_code;
    logic [CODE_W-1:0]    held_q;
    logic [BANKS-1:0]     bank_load;
    logic [ALL_CELLS-1:0] bank_en;
    logic [CODE_W-1:0]    bank_cnt [BANKS];
    logic [TOTAL_W-1:0]   sum_cnt;
    load_mode_e           mode;

    env_delay_line #(
        .CODE_W (CODE_W),
        .DEPTH  (DELAY_DEPTH),
        .SEL_W  (DELAY_SEL_W)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sample_stb),
        .sel_cfg  (delay_cfg),
        .din      (code_in),
        .dout     (delayed_code)
    );

    // Hold the delayed code for the whole sample period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (sample_stb) begin
            held_q <= delayed_code;
        end
    end

    assign mode = single_phase ? LOAD_TOGETHER : LOAD_STAGGERED;

    env_phase_seq #(
        .BANKS (BANKS)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (sample_stb),
        .mode    (mode),
        .load    (bank_load)
    );

    genvar gb;
    generate
        for (gb = 0; gb < BANKS; gb++) begin : g_bank
            env_therm_bank #(
                .CODE_W (CODE_W),
                .COL_W  (COL_W)
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .load    (bank_load[gb]),
                .code_in (held_q),
                .en      (bank_en[gb*CELLS +: CELLS]),
                .count   (bank_cnt[gb])
            );
        end
    endgenerate

    // Add up the per-bank active-cell counts.
    always_comb begin
        sum_cnt = '0;
        for (int b = 0; b < BANKS; b++) begin
            sum_cnt = sum_cnt + TOTAL_W'(bank_cnt[b]);
        end
    end

    // Apply bypass at the outputs.
    assign cell_en      = bypass ? '1 : bank_en;
    assign active_total = bypass ? TOTAL_W'(ALL_CELLS) : sum_cnt;
endmodule

// File: rtl/env_interp_driver_chk.sv
// Module env_interp_driver_chk
// Property checker bound to env_interp_driver. It watches only the ports.
module env_interp_driver_chk #(
    parameter int BANKS   = 4,
    parameter int CELLS   = 64,
    parameter int TOTAL_W = 9
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bypass,
    input logic                     single_phase,
    input logic [BANKS*CELLS-1:0]   cell_en,
    input logic [TOTAL_W-1:0]       active_total
);
    logic [BANKS*CELLS-1:0] prev_en;
    logic [BANKS-1:0]       bank_changed;
    logic [BANKS-1:0]       bank_prefix;
    logic [CELLS-1:0]       slice_now [BANKS];
    logic [CELLS-1:0]       slice_old [BANKS];

    // Keep last cycle's enables for change detection.
    always_ff @(posedge clk) begin
        prev_en <= cell_en;
    end

    // Per-bank change flags and prefix (thermometer) test.
    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            slice_now[b]    = cell_en[b*CELLS +: CELLS];
            slice_old[b]    = prev_en[b*CELLS +: CELLS];
            bank_changed[b] = (slice_now[b] != slice_old[b]);
            bank_prefix[b]  = (((slice_now[b] + 1'b1) & slice_now[b]) == '0);
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (bypass || (cell_en == '0 && active_total == '0)));

    assert_bank_therm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass |-> (&bank_prefix));

    assert_one_bank_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !$past(bypass) && !$past(single_phase)) |-> $onehot0(bank_changed));

    assert_total_popcount_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(active_total) == $countones(cell_en));

    assert_bypass_all_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> ((&cell_en) && int'(active_total) == BANKS * CELLS));
endmodule

bind env_interp_driver env_interp_driver_chk #(
    .BANKS   (BANKS),
    .CELLS   (CELLS),
    .TOTAL_W (TOTAL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bypass       (bypass),
    .single_phase (single_phase),
    .cell_en      (cell_en),
    .active_total (active_total)
);

// File: tb/env_interp_driver_bench.sv
module env_interp_driver_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   code_in = '0;
    logic         sample_stb = 1'b0;
    logic         bypass = 1'b0;
    logic         single_phase = 1'b0;
    logic [3:0]   delay_cfg = '0;
    logic [255:0] cell_en;
    logic [8:0]   active_total;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    env_interp_driver u_env_interp_driver (
        .clk          (clk),
        .rst_n        (rst_n),
        .code_in      (code_in),
        .sample_stb   (sample_stb),
        .bypass       (bypass),
        .single_phase (single_phase),
        .delay_cfg    (delay_cfg),
        .cell_en      (cell_en),
        .active_total (active_total)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] therm(input int v);
        logic [63:0] t;
        for (int i = 0; i < 64; i++) t[i] = (i < v);
        return t;
    endfunction

    function automatic logic [63:0] bank(input int b);
        return cell_en[b*64 +: 64];
    endfunction

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_vec(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input int dly);
        delay_cfg = 4'(dly);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Present one sample and return four fast cycles later, on a negedge.
    task automatic send(input int v);
        code_in = 6'(v);
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic test_reset_R1();
        chk_int("R1 total after reset", int'(active_total), 0);
        chk_int("R1 enables after reset", $countones(cell_en), 0);
    endtask

    task automatic test_pattern_R2();
        int codes [7] = '{1, 7, 8, 9, 42, 63, 0};
        foreach (codes[n]) begin
            send(codes[n]);
            @(negedge clk);
            for (int b = 0; b < 4; b++)
                chk_vec($sformatf("R2 bank%0d code %0d", b, codes[n]), bank(b), therm(codes[n]));
        end
    endtask

    task automatic staircase_R3(input int oldv, input int newv);
        logic [255:0] prev;
        int diff;
        diff = (newv > oldv) ? newv - oldv : oldv - newv;
        code_in = 6'(newv);
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        chk_int("R3 level before bank loads", int'(active_total), 4*oldv);
        prev = cell_en;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            chk_int($sformatf("R3 step %0d of %0d->%0d", k, oldv, newv),
                    int'(active_total), oldv*(4-k) + newv*k);
            chk_int("R5 total equals popcount", int'(active_total), $countones(cell_en));
            if (diff == 1)
                chk_int("R4 one cell toggles per step", $countones(cell_en ^ prev), 1);
            prev = cell_en;
        end
    endtask

    task automatic test_staircase();
        send(20);
        @(negedge clk);
        staircase_R3(20, 40);
        staircase_R3(40, 21);
        staircase_R3(21, 22);
        staircase_R3(22, 21);
        staircase_R3(21, 63);
        staircase_R3(63, 0);
    endtask

    task automatic test_bypass_R6();
        bypass = 1'b1;
        #1;
        chk_int("R6 bypass total", int'(active_total), 256);
        chk_int("R6 bypass enables", $countones(cell_en), 256);
        send(33);
        @(negedge clk);
        chk_int("R6 bypass ignores code", $countones(cell_en), 256);
        bypass = 1'b0;
        #1;
        chk_int("R6 release total", int'(active_total), 132);
        chk_vec("R6 release bank3", bank(3), therm(33));
    endtask

    task automatic test_single_R7();
        single_phase = 1'b1;
        code_in = 6'd10;
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        chk_int("R7 before load", int'(active_total), 132);
        @(negedge clk);
        chk_int("R7 single jump", int'(active_total), 40);
        for (int b = 0; b < 4; b++)
            chk_vec($sformatf("R7 bank%0d", b), bank(b), therm(10));
        repeat (4) @(negedge clk);
        single_phase = 1'b0;
    endtask

    task automatic test_delay_R8();
        int codes [5] = '{10, 20, 30, 40, 50};
        int expv;
        do_reset(3);
        foreach (codes[j]) begin
            send(codes[j]);
            expv = (j < 3) ? 0 : codes[j-3];
            chk_vec($sformatf("R8 delay3 strobe %0d bank0", j), bank(0), therm(expv));
        end
        delay_cfg = 4'd0;
        send(60);
        chk_vec("R8 setting change ignored", bank(0), therm(30));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        do_reset(0);
        test_reset_R1();
        test_pattern_R2();
        test_staircase();
        test_bypass_R6();
        test_single_R7();
        test_delay_R8();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule